// File: doc/BRIEF.md
# Byte-Stream Debug Request Bridge

This block sits between a byte transport (a UART receiver, or a FIFO fed from a network socket) and the valid/ready debug command port of a CPU. It collects fixed-size request packets one byte at a time. Each complete packet is turned into exactly one command on the debug port. A read request returns the word the CPU answers with as four bytes on an outgoing byte stream.

Only two request addresses are recognised. One selects the core debug register and the other selects the data debug register, and each is replaced by a short offset on the debug port. A request to any other address issues no command and raises a one-cycle error pulse. A free-running count of completed commands lets host software notice that a request has been lost. Only one request is in flight at a time. The byte input is closed from the last byte of a packet until that packet's command has completed and any reply has left.

Top module: `dbg_pkt_bridge`

## Requirements
- R1: A request is 10 bytes received in this order: a flag byte (nonzero means write, zero means read), an access-size byte, a 32-bit address, then a 32-bit data word. Both 32-bit fields arrive least significant byte first. The size byte has no effect on the command.
- R2: Request address 0xF00F0000 issues a command with offset 0x00 on `cmd_addr`.
- R3: Request address 0xF00F0004 issues a command with offset 0x04 on `cmd_addr`.
- R4: A request with any other address issues no command and drives `bad_addr` high for exactly one cycle.
- R5: A write request issues a command with `cmd_wr` = 1 and the packet data word on `cmd_data`.
- R6: A read request issues a command with `cmd_wr` = 0 and `cmd_data` = 0, whatever the packet data word holds.
- R7: Once raised, `cmd_valid` and the command fields `cmd_wr`, `cmd_addr` and `cmd_data` stay unchanged until a cycle with `cmd_ready` high. In the cycle after that one, `cmd_valid` and `cmd_wr` are 0.
- R8: For a read, `rsp_data` is captured in the cycle `cmd_ready` is high and is sent on the output stream as 4 bytes, least significant byte first. A write sends no bytes.
- R9: `txn_count` rises by one for each command accepted by the debug port, read or write, and does not change for rejected requests.
- R10: `in_ready` is low while a command is pending or response bytes are still being sent.
- R11: A synchronous `rst` restarts byte collection at the first byte of a packet, clears `txn_count` and drops `cmd_valid`, `out_valid` and `bad_addr`.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request byte available |
| in_data | input | 8 | Request byte |
| in_ready | output | 1 | Bridge takes the request byte this cycle |
| cmd_valid | output | 1 | Debug command pending |
| cmd_wr | output | 1 | Debug command is a write |
| cmd_addr | output | 8 | Debug register offset |
| cmd_data | output | 32 | Debug write payload |
| cmd_ready | input | 1 | Debug port accepts the command |
| rsp_data | input | 32 | Debug read result, valid with cmd_ready |
| out_valid | output | 1 | Response byte available |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Receiver takes the response byte |
| bad_addr | output | 1 | One-cycle pulse for a rejected request address |
| txn_count | output | 32 | Completed debug command count |

## Verification
Writes and reads go to both known addresses. They use unusual flag and size bytes and read packets whose data word is nonzero, which separates a decoder that looks at the right byte slots from one that is off by a byte or that leaks the payload into reads. The debug port answers after zero to several cycles of delay, which shows whether the command is held or released early. The response stream is run both free-flowing and throttled, which exposes byte-order errors and any loss under backpressure. Rejected addresses are mixed between good requests, and a reset is issued halfway through a packet, to show that no stray command or count step appears and that collection restarts on a packet boundary.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_DRAIN = 2'd2
  } issue_st_e;
endpackage

// File: rtl/dbgb_collect.sv
module dbgb_collect #(
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [dbgb_pkg::BYTE_W-1:0] in_data,
  output logic                        in_ready,
  input  logic                        release_i,
  output logic                        pkt_valid,
  output logic                        pkt_wr,
  output logic [WORD_W-1:0]           pkt_addr,
  output logic [WORD_W-1:0]           pkt_data
);
  localparam int BW     = dbgb_pkg::BYTE_W;
  localparam int WB     = WORD_W / BW;
  localparam int PKT_B  = 2 + 2 * WB;
  localparam int KEEP_B = PKT_B - 1;        // size byte is dropped
  localparam int IDX_W  = $clog2(PKT_B + 1);
  localparam int SREG_W = KEEP_B * BW;

  logic [SREG_W-1:0] sreg;
  logic [IDX_W-1:0]  idx;
  logic              full;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      idx  <= '0;
      full <= 1'b0;
    end else begin
      if (in_valid && !full) begin
        if (idx != IDX_W'(1))
          sreg <= {in_data, sreg[SREG_W-1:BW]};
        if (idx == IDX_W'(PKT_B - 1)) begin
          idx  <= '0;
          full <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (release_i)
        full <= 1'b0;
    end
  end

  assign in_ready  = !full;
  assign pkt_valid = full;
  assign pkt_wr    = |sreg[BW-1:0];
  assign pkt_addr  = sreg[BW +: WORD_W];
  assign pkt_data  = sreg[BW+WORD_W +: WORD_W];
endmodule

// File: rtl/dbgb_issue.sv
module dbgb_issue #(
  parameter int                WORD_W    = 32,
  parameter int                OFFS_W    = 8,
  parameter int                CNT_W     = 32,
  parameter logic [WORD_W-1:0] CORE_ADDR = 'hF00F_0000,
  parameter logic [WORD_W-1:0] DATA_ADDR = 'hF00F_0004,
  parameter logic [OFFS_W-1:0] CORE_OFFS = 'h00,
  parameter logic [OFFS_W-1:0] DATA_OFFS = 'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pkt_valid,
  input  logic              pkt_wr,
  input  logic [WORD_W-1:0] pkt_addr,
  input  logic [WORD_W-1:0] pkt_data,
  output logic              release_o,
  output logic              cmd_valid,
  output logic              cmd_wr,
  output logic [OFFS_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_ready,
  input  logic [WORD_W-1:0] rsp_word,
  output logic              ld_o,
  output logic [WORD_W-1:0] ld_word,
  input  logic              ser_busy,
  output logic              bad_addr,
  output logic [CNT_W-1:0]  txn_count
);
  import dbgb_pkg::*;

  issue_st_e st;
  logic hit_core, hit_data, hit;

  assign hit_core = (pkt_addr == CORE_ADDR);
  assign hit_data = (pkt_addr == DATA_ADDR);
  assign hit      = hit_core || hit_data;

  always_comb begin
    release_o = 1'b0;
    case (st)
      ST_IDLE:  release_o = pkt_valid && !hit;
      ST_CMD:   release_o = cmd_ready && cmd_wr;
      ST_DRAIN: release_o = !ser_busy;
      default:  release_o = 1'b0;
    endcase
  end

  assign ld_o    = (st == ST_CMD) && cmd_ready && !cmd_wr;
  assign ld_word = rsp_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cmd_valid <= 1'b0;
      cmd_wr    <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      bad_addr  <= 1'b0;
      txn_count <= '0;
    end else begin
      bad_addr <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (pkt_valid) begin
            if (hit) begin
              cmd_valid <= 1'b1;
              cmd_wr    <= pkt_wr;
              cmd_addr  <= hit_core ? CORE_OFFS : DATA_OFFS;
              cmd_data  <= pkt_wr ? pkt_data : '0;
              st        <= ST_CMD;
            end else begin
              bad_addr <= 1'b1;
            end
          end
        end
        ST_CMD: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            cmd_wr    <= 1'b0;
            txn_count <= txn_count + 1'b1;
            st        <= cmd_wr ? ST_IDLE : ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (!ser_busy)
            st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbgb_ser.sv
module dbgb_ser #(
  parameter int WORD_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ld,
  input  logic [WORD_W-1:0]           ld_word,
  output logic                        out_valid,
  output logic [dbgb_pkg::BYTE_W-1:0] out_data,
  input  logic                        out_ready,
  output logic                        busy
);
  localparam int BW   = dbgb_pkg::BYTE_W;
  localparam int NB   = WORD_W / BW;
  localparam int CW   = $clog2(NB + 1);

  logic [WORD_W-1:0] word;
  logic [CW-1:0]     left;
  logic              vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      left <= '0;
      vld  <= 1'b0;
    end else if (ld) begin
      word <= ld_word;
      left <= CW'(NB);
      vld  <= 1'b1;
    end else if (vld && out_ready) begin
      word <= word >> BW;
      left <= left - 1'b1;
      if (left == CW'(1))
        vld <= 1'b0;
    end
  end

  assign out_valid = vld;
  assign out_data  = word[BW-1:0];
  assign busy      = vld;
endmodule

// File: rtl/dbg_pkt_bridge.sv
module dbg_pkt_bridge #(
  parameter int                WORD_W    = 32,
  parameter int                OFFS_W    = 8,
  parameter int                CNT_W     = 32,
  parameter logic [WORD_W-1:0] CORE_ADDR = 'hF00F_0000,
  parameter logic [WORD_W-1:0] DATA_ADDR = 'hF00F_0004,
  parameter logic [OFFS_W-1:0] CORE_OFFS = 'h00,
  parameter logic [OFFS_W-1:0] DATA_OFFS = 'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              cmd_valid,
  output logic              cmd_wr,
  output logic [OFFS_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_data,
  input  logic              cmd_ready,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              bad_addr,
  output logic [CNT_W-1:0]  txn_count
);
  logic              pkt_valid, pkt_wr, rel, ld, ser_busy;
  logic [WORD_W-1:0] pkt_addr, pkt_data, ld_word;

  dbgb_collect #(.WORD_W(WORD_W)) u_collect (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .release_i(rel),
    .pkt_valid(pkt_valid), .pkt_wr(pkt_wr),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data)
  );

  dbgb_issue #(
    .WORD_W(WORD_W), .OFFS_W(OFFS_W), .CNT_W(CNT_W),
    .CORE_ADDR(CORE_ADDR), .DATA_ADDR(DATA_ADDR),
    .CORE_OFFS(CORE_OFFS), .DATA_OFFS(DATA_OFFS)
  ) u_issue (
    .clk(clk), .rst(rst),
    .pkt_valid(pkt_valid), .pkt_wr(pkt_wr),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data),
    .release_o(rel),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .rsp_word(rsp_data),
    .ld_o(ld), .ld_word(ld_word), .ser_busy(ser_busy),
    .bad_addr(bad_addr), .txn_count(txn_count)
  );

  dbgb_ser #(.WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst(rst),
    .ld(ld), .ld_word(ld_word),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .busy(ser_busy)
  );
endmodule

// File: rtl/dbgb_chk.sv
module dbgb_chk #(
  parameter int OFFS_W = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              cmd_valid,
  input logic              cmd_wr,
  input logic [OFFS_W-1:0] cmd_addr,
  input logic [WORD_W-1:0] cmd_data,
  input logic              cmd_ready,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_ready,
  input logic              bad_addr,
  input logic [CNT_W-1:0]  txn_count
);
  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_wr) && $stable(cmd_addr) && $stable(cmd_data));
  // R7
  cmd_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> !cmd_valid && !cmd_wr);
  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready |=> txn_count == $past(txn_count) + 1'b1);
  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) |=> $stable(txn_count));
  // R10
  one_txn_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid || out_valid |-> !in_ready);
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R4
  bad_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bad_addr |=> !bad_addr);
  // R2
  offs_legal_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_addr == OFFS_W'(0)) || (cmd_addr == OFFS_W'(4)));
  // R6
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_wr |-> cmd_data == '0);
endmodule

bind dbg_pkt_bridge dbgb_chk #(.OFFS_W(OFFS_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
  .cmd_ready(cmd_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .bad_addr(bad_addr), .txn_count(txn_count)
);

// File: tb/sim_dbg_pkt_bridge.sv
module sim_dbg_pkt_bridge;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        cmd_valid, cmd_wr;
  logic [7:0]  cmd_addr;
  logic [31:0] cmd_data;
  logic        cmd_ready = 1'b0;
  logic [31:0] rsp_data = 32'hDEAD_BEEF;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        bad_addr;
  logic [31:0] txn_count;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  int exp_bad = 0;
  int seen_bad = 0;
  bit stall = 1'b0;

  logic        q_wr[$];
  logic [7:0]  q_off[$];
  logic [31:0] q_pay[$];
  logic [31:0] q_rsp[$];
  int          q_dly[$];
  logic [7:0]  q_byte[$];

  always #(CLK_P/2) clk = ~clk;

  dbg_pkt_bridge u0 (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .bad_addr(bad_addr), .txn_count(txn_count)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: pushes expectations, then streams the 10 bytes
  task automatic send_pkt(input logic [7:0] flag, input logic [7:0] size,
                          input logic [31:0] addr, input logic [31:0] data,
                          input logic [31:0] rword, input int dly);
    logic [7:0] b[10];
    b[0] = flag;
    b[1] = size;
    for (int i = 0; i < 4; i++) begin
      b[2+i] = addr[8*i +: 8];
      b[6+i] = data[8*i +: 8];
    end
    if (addr == 32'hF00F_0000 || addr == 32'hF00F_0004) begin
      q_wr.push_back(flag != 0);
      q_off.push_back(addr == 32'hF00F_0000 ? 8'h00 : 8'h04);
      q_pay.push_back(flag != 0 ? data : 32'h0);
      q_rsp.push_back(rword);
      q_dly.push_back(dly);
      if (flag == 0)
        for (int i = 0; i < 4; i++) q_byte.push_back(rword[8*i +: 8]);
    end else begin
      exp_bad++;
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b[i];
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (q_wr.size() == 0 && q_byte.size() == 0 && in_ready && !cmd_valid && !out_valid)
        break;
    end
    @(negedge clk);
  endtask

  // debug port responder: checks command, then answers after a delay
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cmd_valid) begin
        if (q_wr.size() == 0) begin
          chk(1'b0, "R4", "command with no valid request", {24'h0, cmd_addr}, 32'h0);
        end else begin
          logic        e_wr;
          logic [7:0]  e_off;
          logic [31:0] e_pay;
          e_wr = q_wr[0]; e_off = q_off[0]; e_pay = q_pay[0];
          chk(cmd_addr == e_off, e_off == 8'h00 ? "R2" : "R3", "offset", {24'h0, cmd_addr}, {24'h0, e_off});
          chk(cmd_wr == e_wr, e_wr ? "R5" : "R6", "write bit", {31'h0, cmd_wr}, {31'h0, e_wr});
          chk(cmd_data == e_pay, e_wr ? "R5" : "R6", "payload", cmd_data, e_pay);
          for (int k = 0; k < q_dly[0]; k++) begin
            @(negedge clk);
            chk(cmd_valid && cmd_wr == e_wr && cmd_addr == e_off && cmd_data == e_pay,
                "R7", "hold while not ready", cmd_data, e_pay);
          end
          cmd_ready = 1'b1;
          rsp_data  = q_rsp[0];
          @(negedge clk);
          cmd_ready = 1'b0;
          rsp_data  = 32'hDEAD_BEEF;
          done_cnt++;
          chk(!cmd_valid && !cmd_wr, "R7", "drop after ready", {30'h0, cmd_valid, cmd_wr}, 32'h0);
          chk(txn_count == 32'(done_cnt), "R9", "count after command", txn_count, 32'(done_cnt));
          void'(q_wr.pop_front()); void'(q_off.pop_front()); void'(q_pay.pop_front());
          void'(q_rsp.pop_front()); void'(q_dly.pop_front());
        end
      end
    end
  end

  // monitor: response bytes, backpressure, single outstanding, error pulses
  initial begin
    int cyc = 0;
    bit held = 1'b0;
    logic [7:0] held_byte = '0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (!rst) begin
        if (held)
          chk(out_valid && out_data == held_byte, "R12", "byte held under backpressure",
              {24'h0, out_data}, {24'h0, held_byte});
        held = out_valid && !out_ready;
        held_byte = out_data;
        if (cmd_valid || out_valid)
          chk(!in_ready, "R10", "input closed while busy", {31'h0, in_ready}, 32'h0);
        if (bad_addr) seen_bad++;
        if (out_valid && out_ready) begin
          if (q_byte.size() == 0)
            chk(1'b0, "R8", "unexpected response byte", {24'h0, out_data}, 32'h0);
          else
            chk(out_data == q_byte[0], "R8", "response byte", {24'h0, out_data}, {24'h0, q_byte[0]});
          if (q_byte.size() != 0) void'(q_byte.pop_front());
        end
      end else begin
        held = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(in_ready && !cmd_valid && !out_valid && !bad_addr, "R11", "reset outputs",
        {28'h0, in_ready, cmd_valid, out_valid, bad_addr}, 32'h8);
    chk(txn_count == 0, "R11", "reset count", txn_count, 32'h0);
    rst = 1'b0;

    // R1 R2 R5: write core, odd size byte
    send_pkt(8'h01, 8'h04, 32'hF00F_0000, 32'h1234_5678, 32'h0, 0);
    wait_idle();
    // R3 R5: write data, flag 0x7F, delayed ready
    send_pkt(8'h7F, 8'hA5, 32'hF00F_0004, 32'hCAFE_0042, 32'h0, 3);
    wait_idle();
    // R6 R8: read core with nonzero packet data
    send_pkt(8'h00, 8'h04, 32'hF00F_0000, 32'hFFFF_FFFF, 32'hA1B2_C3D4, 2);
    wait_idle();
    // R8 R12: read data under backpressure
    stall = 1'b1;
    send_pkt(8'h00, 8'h01, 32'hF00F_0004, 32'h5555_AAAA, 32'h0F1E_2D3C, 0);
    wait_idle();
    stall = 1'b0;

    // R4 R9: rejected addresses
    send_pkt(8'h01, 8'h04, 32'hF00F_0008, 32'h1111_1111, 32'h0, 0);
    wait_idle();
    send_pkt(8'h00, 8'h04, 32'h000F_0000, 32'h0, 32'h0, 0);
    wait_idle();
    chk(seen_bad == exp_bad, "R4", "error pulse count", 32'(seen_bad), 32'(exp_bad));
    chk(txn_count == 32'(done_cnt), "R9", "count unchanged by rejects", txn_count, 32'(done_cnt));

    // back-to-back mix, stall alternating
    for (int i = 0; i < 6; i++) begin
      stall = i[0];
      send_pkt((i % 3 == 0) ? 8'h00 : 8'(i), 8'(i),
               (i == 4) ? 32'hF00F_0010 : ((i % 2 == 0) ? 32'hF00F_0004 : 32'hF00F_0000),
               32'h0100_0000 * 32'(i + 1) + 32'(i), 32'h8070_6050 + 32'(i * 17), i % 3);
    end
    wait_idle();
    stall = 1'b0;
    chk(seen_bad == exp_bad, "R4", "error pulse count after mix", 32'(seen_bad), 32'(exp_bad));

    // R11: reset in the middle of a packet
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'hF0 + 8'(i);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    done_cnt = 0;
    repeat (2) @(negedge clk);
    chk(txn_count == 0 && !cmd_valid && in_ready, "R11", "mid-packet reset",
        txn_count, 32'h0);
    rst = 1'b0;
    send_pkt(8'h00, 8'h04, 32'hF00F_0004, 32'h0, 32'h7766_5544, 1);
    wait_idle();
    chk(txn_count == 1, "R11", "clean packet after reset", txn_count, 32'h1);

    chk(q_wr.size() == 0, "R9", "commands outstanding", 32'(q_wr.size()), 32'h0);
    chk(q_byte.size() == 0, "R8", "bytes outstanding", 32'(q_byte.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule